// File: doc/BRIEF.md
# Colour Palette Access Port

This block holds a 256-entry colour lookup table of 24-bit red/green/blue entries and gives a host two ways into it through a small register window. A host loads a starting entry number into one of two independent pointer registers, one for loading and one for fetching. It then moves colour bytes through a single data register. Each entry is carried as three byte accesses in the order red, green, blue. After the third byte the pointer moves on to the next entry, so a run of consecutive entries can be streamed without reloading the pointer.

Alongside the host port, a pixel path turns indices into colours. Each index presented with the pixel enable is ANDed with an 8-bit read mask and used to address the table. The red, green and blue result appears on registered outputs one cycle later. Host and pixel traffic share one clock domain.

Top module: `pal_port`

## Requirements
- R1: After reset, both pointers read back as 0, both component sequencers stand at red, the read mask reads back as 0xFF, and host_rvalid, pix_valid and the three colour outputs are 0.
- R2: A write to the load-pointer register (select 1) or the fetch-pointer register (select 2) sets that pointer from the low data byte. Either write returns both component sequencers to red, which discards any partly sent entry. A read of select 1 or select 2 returns the current value of that pointer.
- R3: Writes to the data register (select 0) are taken as red, then green, then blue. The blue write stores all three bytes into the entry at the load pointer, and the load pointer then advances by one, wrapping from 255 to 0.
- R4: A partly written entry (red only, or red and green) is never visible on the pixel path. The entry keeps its previous colour until the blue byte arrives.
- R5: Reads of the data register return the red, green and blue bytes of the entry at the fetch pointer in that order. After the blue byte the fetch pointer advances by one, wrapping from 255 to 0.
- R6: A host read places its result on host_rdata in the cycle after the read strobe, with host_rvalid high for exactly that one cycle.
- R7: Only bits [7:0] of host_wdata take effect. All higher bits are ignored.
- R8: The read mask register (select 3) can be written and read back. Every pixel index is ANDed with the mask before the lookup.
- R9: A lookup made with pix_en sets pix_valid and the colour outputs on the next clock edge. While pix_en is low, pix_valid is 0 and the colour outputs hold their last value.
- R10: The register select is host_addr[4:3]: 0 is data, 1 is the load pointer, 2 is the fetch pointer, 3 is the mask. Registers occupy 8-byte slots, so host_addr[2:0] is ignored.
- R11: If host_wr and host_rd are both asserted, only the write is performed. The read has no effect on the fetch side, and host_rvalid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for host and pixel traffic |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one per cycle |
| host_rd | input | 1 | Host read strobe, one per cycle |
| host_addr | input | HOST_AW (5) | Byte address; bits [4:3] pick the register |
| host_wdata | input | HOST_DW (32) | Write data; only the low byte is used |
| host_rdata | output | 8 | Read result, valid with host_rvalid |
| host_rvalid | output | 1 | High for one cycle after an accepted read |
| pix_en | input | 1 | Pixel lookup request |
| pix_idx | input | IDX_W (8) | Pixel colour index |
| pix_valid | output | 1 | Colour outputs refreshed by the previous lookup |
| pix_red | output | 8 | Red component of the lookup |
| pix_green | output | 8 | Green component of the lookup |
| pix_blue | output | 8 | Blue component of the lookup |

## Verification
On every cycle, the assertions check the pointer bookkeeping and the timing of the read and pixel handshakes. The pointers may move only on a blue-byte access or a pointer load, and each such move is checked as a step of one. Pointer loads must return the sequencers to red, and the mask may change only on its own write. The pixel and read-valid signals must follow their strobes by exactly one cycle. What the assertions cannot see is whether the right bytes land in the right entries. The bench scenarios show this by comparing against a model of the table: colours streamed back, entries wrapping at 255, partial entries that stay invisible, masked indices that select the intended entry, and upper data or address bits that have no effect.

// File: rtl/pal_pkg.sv
package pal_pkg;

    typedef enum logic [1:0] {
        SEL_DATA   = 2'd0,
        SEL_WSTART = 2'd1,
        SEL_RSTART = 2'd2,
        SEL_MASK   = 2'd3
    } pal_sel_e;

    typedef enum logic [1:0] {
        COMP_R = 2'd0,
        COMP_G = 2'd1,
        COMP_B = 2'd2
    } pal_comp_e;

    localparam int unsigned CW = 8;

endpackage

// File: rtl/pal_lut_ram.sv
module pal_lut_ram #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned ENT_W = 24
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [ENT_W-1:0] wdata,
    input  logic [IDX_W-1:0] ra_addr,
    output logic [ENT_W-1:0] ra_data,
    input  logic [IDX_W-1:0] rb_addr,
    output logic [ENT_W-1:0] rb_data
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [ENT_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign ra_data = mem_q[ra_addr];
    assign rb_data = mem_q[rb_addr];

endmodule

// File: rtl/pal_host_ctl.sv
module pal_host_ctl
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_sel,
    input  logic [CW-1:0]     host_byte,
    output logic              ram_we,
    output logic [IDX_W-1:0]  ram_waddr,
    output logic [3*CW-1:0]   ram_wdata,
    output logic [IDX_W-1:0]  ram_raddr,
    input  logic [3*CW-1:0]   ram_rdata,
    output logic [CW-1:0]     host_rdata,
    output logic              host_rvalid,
    output logic [CW-1:0]     mask_o,
    output logic [IDX_W-1:0]  wptr_o,
    output logic [IDX_W-1:0]  rptr_o,
    output logic [1:0]        wcomp_o,
    output logic [1:0]        rcomp_o
);
    typedef struct packed {
        logic [IDX_W-1:0] wptr;
        logic [IDX_W-1:0] rptr;
        pal_comp_e        wcomp;
        pal_comp_e        rcomp;
        logic [CW-1:0]    hold_r;
        logic [CW-1:0]    hold_g;
        logic [CW-1:0]    mask;
        logic [CW-1:0]    rdata;
        logic             rvalid;
    } ctl_s;

    ctl_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rvalid = 1'b0;
        ram_we    = 1'b0;
        ram_waddr = st_q.wptr;
        ram_wdata = {st_q.hold_r, st_q.hold_g, host_byte};
        if (host_wr) begin
            case (pal_sel_e'(host_sel))
                SEL_DATA: begin
                    case (st_q.wcomp)
                        COMP_R: begin
                            st_d.hold_r = host_byte;
                            st_d.wcomp  = COMP_G;
                        end
                        COMP_G: begin
                            st_d.hold_g = host_byte;
                            st_d.wcomp  = COMP_B;
                        end
                        default: begin
                            ram_we     = 1'b1;
                            st_d.wptr  = st_q.wptr + 1'b1;
                            st_d.wcomp = COMP_R;
                        end
                    endcase
                end
                SEL_WSTART: begin
                    st_d.wptr  = host_byte[IDX_W-1:0];
                    st_d.wcomp = COMP_R;
                    st_d.rcomp = COMP_R;
                end
                SEL_RSTART: begin
                    st_d.rptr  = host_byte[IDX_W-1:0];
                    st_d.wcomp = COMP_R;
                    st_d.rcomp = COMP_R;
                end
                default: begin
                    st_d.mask = host_byte;
                end
            endcase
        end else if (host_rd) begin
            st_d.rvalid = 1'b1;
            case (pal_sel_e'(host_sel))
                SEL_DATA: begin
                    case (st_q.rcomp)
                        COMP_R: begin
                            st_d.rdata = ram_rdata[3*CW-1:2*CW];
                            st_d.rcomp = COMP_G;
                        end
                        COMP_G: begin
                            st_d.rdata = ram_rdata[2*CW-1:CW];
                            st_d.rcomp = COMP_B;
                        end
                        default: begin
                            st_d.rdata = ram_rdata[CW-1:0];
                            st_d.rptr  = st_q.rptr + 1'b1;
                            st_d.rcomp = COMP_R;
                        end
                    endcase
                end
                SEL_WSTART: st_d.rdata = CW'(st_q.wptr);
                SEL_RSTART: st_d.rdata = CW'(st_q.rptr);
                default:    st_d.rdata = st_q.mask;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.wcomp <= COMP_R;
            st_q.rcomp <= COMP_R;
            st_q.mask  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ram_raddr   = st_q.rptr;
    assign host_rdata  = st_q.rdata;
    assign host_rvalid = st_q.rvalid;
    assign mask_o      = st_q.mask;
    assign wptr_o      = st_q.wptr;
    assign rptr_o      = st_q.rptr;
    assign wcomp_o     = st_q.wcomp;
    assign rcomp_o     = st_q.rcomp;

endmodule

// File: rtl/pal_pixel_stage.sv
module pal_pixel_stage
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic [IDX_W-1:0] pix_idx,
    input  logic [CW-1:0]    mask,
    output logic [IDX_W-1:0] lut_addr,
    input  logic [3*CW-1:0]  lut_data,
    output logic             pix_valid,
    output logic [3*CW-1:0]  pix_rgb
);
    typedef struct packed {
        logic            valid;
        logic [3*CW-1:0] rgb;
    } pix_s;

    pix_s px_d, px_q;

    always_comb begin
        lut_addr   = pix_idx & mask[IDX_W-1:0];
        px_d       = px_q;
        px_d.valid = pix_en;
        if (pix_en) begin
            px_d.rgb = lut_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px_q <= '0;
        end else begin
            px_q <= px_d;
        end
    end

    assign pix_valid = px_q.valid;
    assign pix_rgb   = px_q.rgb;

endmodule

// File: rtl/pal_port.sv
module pal_port
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W   = 8,
    parameter int unsigned HOST_DW = 32,
    parameter int unsigned HOST_AW = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [CW-1:0]      host_rdata,
    output logic               host_rvalid,
    input  logic               pix_en,
    input  logic [IDX_W-1:0]   pix_idx,
    output logic               pix_valid,
    output logic [CW-1:0]      pix_red,
    output logic [CW-1:0]      pix_green,
    output logic [CW-1:0]      pix_blue
);
    localparam int unsigned SEL_LSB = 3;
    localparam int unsigned ENT_W   = 3 * CW;

    logic [1:0]       host_sel;
    logic             ram_we;
    logic [IDX_W-1:0] ram_waddr;
    logic [ENT_W-1:0] ram_wdata;
    logic [IDX_W-1:0] ram_raddr;
    logic [ENT_W-1:0] ram_rdata;
    logic [IDX_W-1:0] lut_addr;
    logic [ENT_W-1:0] lut_data;
    logic [ENT_W-1:0] pix_rgb;
    logic [CW-1:0]    mask_w;
    logic [IDX_W-1:0] wptr_w;
    logic [IDX_W-1:0] rptr_w;
    logic [1:0]       wcomp_w;
    logic [1:0]       rcomp_w;
    logic             unused_host_bits;

    assign host_sel         = host_addr[SEL_LSB+1:SEL_LSB];
    assign unused_host_bits = ^{host_addr[SEL_LSB-1:0], host_wdata[HOST_DW-1:CW]};

    pal_host_ctl #(.IDX_W(IDX_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_sel   (host_sel),
        .host_byte  (host_wdata[CW-1:0]),
        .ram_we     (ram_we),
        .ram_waddr  (ram_waddr),
        .ram_wdata  (ram_wdata),
        .ram_raddr  (ram_raddr),
        .ram_rdata  (ram_rdata),
        .host_rdata (host_rdata),
        .host_rvalid(host_rvalid),
        .mask_o     (mask_w),
        .wptr_o     (wptr_w),
        .rptr_o     (rptr_w),
        .wcomp_o    (wcomp_w),
        .rcomp_o    (rcomp_w)
    );

    pal_lut_ram #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_ram (
        .clk    (clk),
        .we     (ram_we),
        .waddr  (ram_waddr),
        .wdata  (ram_wdata),
        .ra_addr(ram_raddr),
        .ra_data(ram_rdata),
        .rb_addr(lut_addr),
        .rb_data(lut_data)
    );

    pal_pixel_stage #(.IDX_W(IDX_W)) u_pix (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_en   (pix_en),
        .pix_idx  (pix_idx),
        .mask     (mask_w),
        .lut_addr (lut_addr),
        .lut_data (lut_data),
        .pix_valid(pix_valid),
        .pix_rgb  (pix_rgb)
    );

    assign pix_red   = pix_rgb[3*CW-1:2*CW];
    assign pix_green = pix_rgb[2*CW-1:CW];
    assign pix_blue  = pix_rgb[CW-1:0];

endmodule

// File: rtl/pal_port_chk.sv
module pal_port_chk #(
    parameter int unsigned IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic             host_rd,
    input logic [1:0]       host_sel,
    input logic             host_rvalid,
    input logic             pix_en,
    input logic             pix_valid,
    input logic [7:0]       pix_red,
    input logic [7:0]       pix_green,
    input logic [7:0]       pix_blue,
    input logic [7:0]       mask_w,
    input logic [IDX_W-1:0] wptr_w,
    input logic [IDX_W-1:0] rptr_w,
    input logic [1:0]       wcomp_w,
    input logic [1:0]       rcomp_w
);
    logic wr_blue, rd_blue, ptr_load;
    assign wr_blue  = host_wr && host_sel == 2'd0 && wcomp_w == 2'd2;
    assign rd_blue  = host_rd && !host_wr && host_sel == 2'd0 && rcomp_w == 2'd2;
    assign ptr_load = host_wr && (host_sel == 2'd1 || host_sel == 2'd2);

    assert_rvalid_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(host_rd && !host_wr));

    assert_read_answered_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr) |=> host_rvalid);

    assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_wr) |=> !host_rvalid);

    assert_wptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_blue |=> wptr_w == IDX_W'($past(wptr_w) + 1'b1));

    assert_wptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_blue || (host_wr && host_sel == 2'd1)) |=> $stable(wptr_w));

    assert_rptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_blue |=> rptr_w == IDX_W'($past(rptr_w) + 1'b1));

    assert_rptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_blue || (host_wr && host_sel == 2'd2)) |=> $stable(rptr_w));

    assert_load_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |=> (wcomp_w == 2'd0 && rcomp_w == 2'd0));

    assert_comp_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wcomp_w != 2'd3 && rcomp_w != 2'd3);

    assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_sel == 2'd3) |=> $stable(mask_w));

    assert_pix_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en |=> pix_valid);

    assert_pix_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> (!pix_valid && $stable({pix_red, pix_green, pix_blue})));

endmodule

bind pal_port pal_port_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_sel   (host_sel),
    .host_rvalid(host_rvalid),
    .pix_en     (pix_en),
    .pix_valid  (pix_valid),
    .pix_red    (pix_red),
    .pix_green  (pix_green),
    .pix_blue   (pix_blue),
    .mask_w     (mask_w),
    .wptr_w     (wptr_w),
    .rptr_w     (rptr_w),
    .wcomp_w    (wcomp_w),
    .rcomp_w    (rcomp_w)
);

// File: tb/pal_port_tb.sv
`timescale 1ns/1ps
module pal_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_rvalid;
    logic        pix_en = 1'b0;
    logic [7:0]  pix_idx = '0;
    logic        pix_valid;
    logic [7:0]  pix_red, pix_green, pix_blue;

    int checks = 0;
    int fails  = 0;
    logic [23:0] model [256];

    always #2.5 clk = ~clk;

    pal_port u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .pix_en(pix_en), .pix_idx(pix_idx),
        .pix_valid(pix_valid), .pix_red(pix_red), .pix_green(pix_green),
        .pix_blue(pix_blue)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [1:0] sel, input logic [31:0] d, input logic [2:0] lo = 3'd0);
        @(negedge clk);
        host_wr = 1'b1; host_addr = {sel, lo}; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = 32'hDEAD_BEEF;
    endtask

    task automatic hrd(input string req, input logic [1:0] sel, input logic [7:0] exp);
        @(negedge clk);
        host_rd = 1'b1; host_addr = {sel, 3'd0};
        @(negedge clk);
        host_rd = 1'b0;
        check({req, " rvalid"}, 32'(host_rvalid), 32'd1);
        check(req, 32'(host_rdata), 32'(exp));
    endtask

    task automatic put_entry(input logic [7:0] idx_now, input logic [23:0] rgb);
        hwr(2'd0, {24'hA5A5A5, rgb[23:16]});
        hwr(2'd0, {24'h5A5A5A, rgb[15:8]}, 3'd6);
        hwr(2'd0, {24'hFFFFFF, rgb[7:0]});
        model[idx_now] = rgb;
    endtask

    task automatic lookup(input string req, input logic [7:0] idx, input logic [23:0] exp);
        logic [23:0] got;
        @(negedge clk);
        pix_en = 1'b1; pix_idx = idx;
        @(negedge clk);
        pix_en = 1'b0; pix_idx = ~idx;
        got = {pix_red, pix_green, pix_blue};
        check({req, " pix_valid"}, 32'(pix_valid), 32'd1);
        check(req, 32'(got), 32'(exp));
        @(negedge clk);
        check("R9 valid drops", 32'(pix_valid), 32'd0);
        check("R9 colour held", 32'({pix_red, pix_green, pix_blue}), 32'(got));
    endtask

    task automatic t_reset;
        check("R1 rvalid", 32'(host_rvalid), 32'd0);
        check("R1 pix_valid", 32'(pix_valid), 32'd0);
        check("R1 colour", 32'({pix_red, pix_green, pix_blue}), 32'd0);
        hrd("R1 mask", 2'd3, 8'hFF);
        hrd("R1 wptr", 2'd1, 8'h00);
        hrd("R1 rptr", 2'd2, 8'h00);
    endtask

    task automatic t_load_and_lookup;
        hwr(2'd1, 32'hFFFF_FF10, 3'd7);
        put_entry(8'h10, 24'h123456);
        put_entry(8'h11, 24'hABCDEF);
        put_entry(8'h12, 24'h0F1E2D);
        hrd("R3 wptr after 3 entries", 2'd1, 8'h13);
        lookup("R3 entry 10", 8'h10, 24'h123456);
        lookup("R7 entry 11", 8'h11, 24'hABCDEF);
        lookup("R10 entry 12", 8'h12, 24'h0F1E2D);
    endtask

    task automatic t_stream_read;
        hwr(2'd2, 32'h0000_0010);
        for (int e = 0; e < 3; e++) begin
            hrd("R5 red", 2'd0, model[8'h10 + e][23:16]);
            hrd("R5 green", 2'd0, model[8'h10 + e][15:8]);
            hrd("R5 blue", 2'd0, model[8'h10 + e][7:0]);
        end
        hrd("R2 rptr readback", 2'd2, 8'h13);
    endtask

    task automatic t_partial;
        hwr(2'd1, 32'h0000_0011);
        hwr(2'd0, 32'h0000_0077);
        lookup("R4 after red only", 8'h11, model[8'h11]);
        hwr(2'd0, 32'h0000_0088);
        lookup("R4 after red+green", 8'h11, model[8'h11]);
        hwr(2'd0, 32'h0000_0099);
        model[8'h11] = 24'h778899;
        lookup("R4 after blue", 8'h11, 24'h778899);
    endtask

    task automatic t_wrap;
        hwr(2'd1, 32'h0000_00FF);
        put_entry(8'hFF, 24'hC0FFEE);
        put_entry(8'h00, 24'h00BEEF);
        hrd("R3 wptr wrapped", 2'd1, 8'h01);
        lookup("R3 entry 00 after wrap", 8'h00, 24'h00BEEF);
        hwr(2'd2, 32'h0000_00FF);
        hrd("R5 red ff", 2'd0, 8'hC0);
        hrd("R5 green ff", 2'd0, 8'hFF);
        hrd("R5 blue ff", 2'd0, 8'hEE);
        hrd("R5 red 00 after wrap", 2'd0, 8'h00);
        hrd("R5 green 00", 2'd0, 8'hBE);
        hrd("R5 blue 00", 2'd0, 8'hEF);
        hrd("R5 rptr wrapped", 2'd2, 8'h01);
    endtask

    task automatic t_restart;
        hwr(2'd1, 32'h0000_0020);
        hwr(2'd0, 32'h0000_00AA);
        hwr(2'd0, 32'h0000_00BB);
        hwr(2'd1, 32'h0000_0020);
        put_entry(8'h20, 24'hCCDDEE);
        lookup("R2 restart write", 8'h20, 24'hCCDDEE);
        hwr(2'd2, 32'h0000_0020);
        hrd("R2 first red", 2'd0, 8'hCC);
        hwr(2'd2, 32'h0000_0010);
        hrd("R2 red after reload", 2'd0, model[8'h10][23:16]);
    endtask

    task automatic t_mask;
        hwr(2'd3, 32'hFFFF_FFF0, 3'd3);
        hrd("R8 mask readback", 2'd3, 8'hF0);
        lookup("R8 masked 1A->10", 8'h1A, model[8'h10]);
        lookup("R8 masked 2F->20", 8'h2F, 24'hCCDDEE);
        hwr(2'd3, 32'h0000_00FF);
        lookup("R8 full mask", 8'h12, model[8'h12]);
    endtask

    task automatic t_collide;
        @(negedge clk);
        host_wr = 1'b1; host_rd = 1'b1; host_addr = 5'b11_000; host_wdata = 32'h33;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        check("R11 no rvalid", 32'(host_rvalid), 32'd0);
        hrd("R11 write performed", 2'd3, 8'h33);
        hwr(2'd2, 32'h0000_0010);
        @(negedge clk);
        host_wr = 1'b1; host_rd = 1'b1; host_addr = 5'b11_000; host_wdata = 32'hFF;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        hrd("R11 fetch side untouched", 2'd0, model[8'h10][23:16]);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_and_lookup();
        t_stream_read();
        t_partial();
        t_wrap();
        t_restart();
        t_mask();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule